// File: doc/BRIEF.md
# Lock-After-First-Write Watchdog Timer

This block is a watchdog timer with a single write-only register. The first write that hits the register address configures the whole timer at once: a 12-bit reload count, a choice between counting every tick or every 16384th tick, an enable, and a 2-bit routing field for the expiry signal. After that write the configuration is frozen until reset. Every later write to the same address, whatever data it carries, restarts the countdown from the frozen reload value.

The countdown runs on a tick at half the bus clock rate. The tick is a clock enable made inside the block, not a derived clock. When the down-counter is already at zero and another count step arrives, the timer expires. It then raises a level-high interrupt request that stays high until reset. A reload value of N therefore gives N+1 count steps before expiry.

The control is a four-state machine. `ST_UNCONF` waits for the configuring write. The edge `take_cfg` leads to `ST_COUNTING` when the enable bit is set, and to `ST_HALTED` when it is clear. `ST_COUNTING` has a self-loop `retrigger` on each register write, and the edge `expire` to `ST_EXPIRED`. `ST_HALTED` and `ST_EXPIRED` are left only by reset, which returns the machine to `ST_UNCONF`.

Top module: `lockwdt_top`

## Requirements
- R1: After reset, `irq` is 0, `irq_route` is 0 and the register accepts a new configuration.
- R2: The first write with `wr_addr` equal to the register address (0) captures the configuration. Bits [11:0] are the reload value N, bit 12 selects the prescaler, bit 13 is the enable, and bits [15:14] are the routing field, which appears on `irq_route` from the next cycle.
- R3: With bit 12 clear and the enable set, `irq` is still 0 after the 2(N+1)-1-th rising edge following the capturing edge, and it is 1 after the 2(N+1)-th.
- R4: With bit 12 set, one count step takes 16384 half-rate ticks, so `irq` rises exactly 2·16384·(N+1) rising edges after the capturing edge.
- R5: Once configured, later writes never change the reload value, the prescaler choice, the enable or `irq_route`, whatever their data.
- R6: A write to the register address while counting, including data 0, restarts the full interval: `irq` rises 2(N+1) edges after that write's capturing edge (without prescaler).
- R7: Once `irq` is 1 it stays 1 until reset, including across further writes.
- R8: If the configuring write has the enable bit clear, the timer never counts and never fires, and a later write with the enable set does not start it.
- R9: Writes to any other address have no effect: they neither configure nor retrigger.
- R10: Reset unlocks the register, so that a new first write applies a new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address; the register is at 0 |
| wr_data | input | 16 | Write data (configuration on first write, ignored afterwards) |
| irq | output | 1 | Level-high expiry interrupt request, held until reset |
| irq_route | output | 2 | Frozen routing field from the configuring write |

## Verification
The hardest situation to reach from the ports is proof that a write made after locking really was ignored. The reload, enable and prescaler bits have no readback path. The stimulus therefore sends retrigger writes whose data carries a different reload value, or tries to switch the enable on in the halted state, and then times the next expiry edge to the exact cycle. Any change to the frozen settings would shift that edge. The prescaled path needs more than thirty thousand cycles per count step, so it is reached with the two smallest reload values only.

// File: rtl/lockwdt_pkg.sv
package lockwdt_pkg;

    typedef enum logic [1:0] {
        ST_UNCONF   = 2'd0,
        ST_HALTED   = 2'd1,
        ST_COUNTING = 2'd2,
        ST_EXPIRED  = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/lockwdt_half_tick.sv
module lockwdt_half_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart)
            phase_q <= 1'b0;
        else
            phase_q <= ~phase_q;
    end

    assign tick = run && !restart && phase_q;
endmodule

// File: rtl/lockwdt_prescaler.sv
module lockwdt_prescaler #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    input  logic bypass,
    output logic step
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            div_q <= '0;
        else if (tick_in && !bypass)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    assign step = tick_in && (bypass || (div_q == LAST));
endmodule

// File: rtl/lockwdt_downcnt.sv
module lockwdt_downcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_zero,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign at_zero = (cnt_q == '0);
    assign value   = cnt_q;
endmodule

// File: rtl/lockwdt_top.sv
module lockwdt_top
    import lockwdt_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int SEL_W    = 2,
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0,
    parameter int PRE_DIV  = 16384,
    localparam int CFG_W   = CNT_W + 2 + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic              irq,
    output logic [SEL_W-1:0]  irq_route
);
    localparam int PSEL_BIT = CNT_W;
    localparam int EN_BIT   = CNT_W + 1;
    localparam int SEL_LSB  = CNT_W + 2;

    wdt_state_e state_q, state_d;

    logic [CNT_W-1:0] reload_q;
    logic             psel_q;
    logic [SEL_W-1:0] route_q;

    logic wr_hit, take_cfg, restart, run;
    logic half_tick, step, at_zero;
    logic [CNT_W-1:0] cnt_val, load_val;

    assign wr_hit   = wr_en && (wr_addr == ADDR_W'(REG_ADDR));
    assign take_cfg = wr_hit && (state_q == ST_UNCONF);
    assign run      = (state_q == ST_COUNTING);
    assign restart  = run && wr_hit;
    assign load_val = take_cfg ? wr_data[CNT_W-1:0] : reload_q;

    // frozen configuration, written only on the locking write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            psel_q   <= 1'b0;
            route_q  <= '0;
        end else if (take_cfg) begin
            reload_q <= wr_data[CNT_W-1:0];
            psel_q   <= wr_data[PSEL_BIT];
            route_q  <= wr_data[SEL_LSB +: SEL_W];
        end
    end

    lockwdt_half_tick u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (half_tick)
    );

    lockwdt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!run || restart),
        .tick_in (half_tick),
        .bypass  (!psel_q),
        .step    (step)
    );

    lockwdt_downcnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cfg || restart),
        .load_val (load_val),
        .dec      (step),
        .at_zero  (at_zero),
        .value    (cnt_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_UNCONF;
        else
            state_q <= state_d;
    end

    // transitions: take_cfg, retrigger, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCONF: begin
                if (wr_hit)
                    state_d = wr_data[EN_BIT] ? ST_COUNTING : ST_HALTED;
            end
            ST_HALTED:   state_d = ST_HALTED;
            ST_COUNTING: begin
                if (!wr_hit && step && at_zero)
                    state_d = ST_EXPIRED;
            end
            ST_EXPIRED:  state_d = ST_EXPIRED;
            default:     state_d = ST_UNCONF;
        endcase
    end

    // outputs
    always_comb begin
        irq       = (state_q == ST_EXPIRED);
        irq_route = route_q;
    end
endmodule

// File: rtl/lockwdt_chk.sv
module lockwdt_chk #(
    parameter int CNT_W    = 12,
    parameter int SEL_W    = 2,
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq,
    input logic [SEL_W-1:0]  irq_route,
    input logic [1:0]        state_q,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  reload_q
);
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(REG_ADDR));

    a_r1_unconf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd0) |-> (!irq && irq_route == '0));

    a_r5_route_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != 2'd0) |=> ((state_q != 2'd0) && $stable(irq_route)));

    a_r6_retrigger_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd2 && hit) |=> (cnt_val == reload_q));

    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd2) |-> (cnt_val <= reload_q));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);

    a_r3_fire_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt_val) == '0 && !$past(hit)));
endmodule

bind lockwdt_top lockwdt_chk #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq       (irq),
    .irq_route (irq_route),
    .state_q   (state_q),
    .cnt_val   (cnt_val),
    .reload_q  (reload_q)
);

// File: tb/lockwdt_top_tb.sv
module lockwdt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq;
    logic [1:0]  irq_route;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    localparam int DIV = 16384;

    lockwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq), .irq_route(irq_route)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 195000 && !done) begin
            done = 1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected<195000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_addr = '0;
    endtask

    function automatic logic [15:0] cfg(input int n, input bit pre, input bit en, input int sel);
        return {sel[1:0], en, pre, n[11:0]};
    endfunction

    // config then check fire edge exactly at 2(N+1) edges
    task automatic run_plain(input int n, input int sel);
        do_reset();
        chk("R1 irq after reset", irq, 0);
        wr(4'd0, cfg(n, 0, 1, sel));
        chk("R2 route captured", irq_route, sel);
        wait_n(2 * (n + 1) - 1);
        chk("R3 irq low before expiry", irq, 0);
        wait_n(1);
        chk("R3 irq high at expiry", irq, 1);
    endtask

    initial begin
        do_reset();
        chk("R1 irq reset", irq, 0);
        chk("R1 route reset", irq_route, 0);

        // sweep of reload values without prescaler
        for (int n = 0; n < 24; n++) run_plain(n, n % 4);
        run_plain(4095, 2);

        // R7 sticky, including a later write
        wait_n(40);
        chk("R7 irq held", irq, 1);
        wr(4'd0, 16'h0000);
        wait_n(3);
        chk("R7 irq held after write", irq, 1);

        // R6 retrigger with data zero
        do_reset();
        wr(4'd0, cfg(10, 0, 1, 1));
        wait_n(15);
        wr(4'd0, 16'h0000);
        wait_n(21);
        chk("R6 low before retriggered expiry", irq, 0);
        wait_n(1);
        chk("R6 high at retriggered expiry", irq, 1);

        // R5 retrigger data with a different reload/route/prescaler is ignored
        do_reset();
        wr(4'd0, cfg(10, 0, 1, 2));
        wait_n(5);
        wr(4'd0, cfg(1, 1, 0, 1));
        chk("R5 route unchanged", irq_route, 2);
        wait_n(21);
        chk("R5 low, reload kept", irq, 0);
        wait_n(1);
        chk("R5 high, reload kept", irq, 1);

        // R9 write to other address ignored while counting and before config
        do_reset();
        wr(4'd3, cfg(0, 0, 1, 3));
        wait_n(10);
        chk("R9 no config from other address irq", irq, 0);
        chk("R9 no config from other address route", irq_route, 0);
        wr(4'd0, cfg(5, 0, 1, 1));
        wait_n(4);
        wr(4'd7, 16'h0000);
        wait_n(5);
        chk("R9 no retrigger, still low", irq, 0);
        wait_n(1);
        chk("R9 no retrigger, fires on time", irq, 1);

        // R8 disabled configuration locks
        do_reset();
        wr(4'd0, cfg(0, 0, 0, 3));
        wait_n(100);
        chk("R8 disabled never fires", irq, 0);
        wr(4'd0, cfg(0, 0, 1, 1));
        wait_n(100);
        chk("R8 later enable ignored", irq, 0);
        chk("R8 route from first write", irq_route, 3);

        // R10 reset reopens configuration
        do_reset();
        chk("R10 route cleared", irq_route, 0);
        wr(4'd0, cfg(3, 0, 1, 1));
        chk("R10 new route", irq_route, 1);
        wait_n(7);
        chk("R10 low", irq, 0);
        wait_n(1);
        chk("R10 high", irq, 1);

        // R4 prescaled timing, N = 0 and N = 1
        for (int n = 0; n < 2; n++) begin
            do_reset();
            wr(4'd0, cfg(n, 1, 1, 0));
            wait_n(2 * DIV * (n + 1) - 1);
            chk("R4 prescaled low before expiry", irq, 0);
            wait_n(1);
            chk("R4 prescaled high at expiry", irq, 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule